// File: doc/BRIEF.md
# Oversampling Serial Receiver with Sleep and Wake

This block turns an asynchronous serial line into parallel words. A free-running divider derives a sample tick from the system clock, and every bit cell spans sixteen ticks. Three samples around the middle of each cell are combined by majority vote. Each finished frame produces one word, a one-cycle strobe, and flags for stop-bit failure, parity mismatch and sample disagreement, along with a summary error bit.

The host can put the receiver to sleep. It then keeps decoding the line but hands nothing out until a wake condition occurs. In idle mode that condition is a quiet line for one whole frame length. In marked mode it is a frame whose top data bit is set, and that frame is delivered. This lets a node ignore traffic meant for other nodes without software handling every word.

Top module: `uwr_rx_top`

## Requirements
- R1: The sample tick fires once every `baud_div` clock cycles, and once every cycle when `baud_div` is 0 or 1. A bit cell lasts 16 ticks, and frames sent at 16×`baud_div` clocks per bit are received correctly for any divisor.
- R2: A frame is a low start bit, then the data bits least significant first, an optional parity bit, and a stop bit. `nine_bit`=1 selects 9 data bits and 0 selects 8. In 8-bit mode `rx_data[8]` reads 0.
- R3: With `par_en`=1, a parity bit follows the data. `par_odd`=0 requires an even count of ones over data and parity, and `par_odd`=1 requires an odd count. A mismatch sets `err_parity` with the word.
- R4: A stop bit that samples low sets `err_frame` with the word.
- R5: Each bit takes the majority of samples 7, 8 and 9 of its cell. If any of those three samples differs in any bit of the frame, `err_noise` is set, and the data still follows the majority.
- R6: `err_any` equals the OR of `err_frame`, `err_parity` and `err_noise` for the same word.
- R7: `rx_valid` is a single-cycle pulse, once per delivered frame. `rx_data` and the flags hold their values until the next delivery.
- R8: A low pulse that is high again at the mid-cell samples is dropped as a false start, and no word is produced.
- R9: A `sleep_req` pulse sets `asleep` on the next cycle. Frames that end while asleep produce no strobe and leave `rx_data` unchanged.
- R10: With `wake_addr`=0, a sleeping receiver wakes after the line has stayed high for (10 + `nine_bit` + `par_en`) × 16 consecutive ticks.
- R11: With `wake_addr`=1, a sleeping receiver stays asleep through frames whose top data bit (bit 7, or bit 8 in 9-bit mode) is 0. A frame with that bit at 1 wakes it, and that frame is delivered.
- R12: After reset, `rx_valid`, `rx_data`, every error flag and `asleep` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial line, idle high |
| baud_div | input | 13 | Clock cycles per sample tick |
| nine_bit | input | 1 | 1: 9 data bits, 0: 8 data bits |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| wake_addr | input | 1 | Wake method: 1 marked frame, 0 idle line |
| sleep_req | input | 1 | Pulse to enter sleep |
| rx_data | output | 9 | Last delivered word |
| rx_valid | output | 1 | One-cycle strobe for a new word |
| err_frame | output | 1 | Stop bit was low |
| err_parity | output | 1 | Parity mismatch |
| err_noise | output | 1 | Sample disagreement in the frame |
| err_any | output | 1 | Summary error bit packed with the word |
| asleep | output | 1 | Receiver is sleeping |

## Verification
A sample counter off by one tick moves the sampling point within a few bits. The first multi-bit word then comes out shifted or with a wrong stop verdict. A wrong bit count in the shifter shows up as a wrong word on the very next frame. A stuck or wrongly reset sleep state shows at the ports within one frame: a word is lost or an extra word is delivered, and the scoreboard either runs dry or reports a word it did not expect. Idle-wake counter errors appear as `asleep` changing too early or too late, and the bench checks the level before and after the threshold.

// File: rtl/uwr_pkg.sv
package uwr_pkg;

  localparam int DW = 9;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_START,
    FS_DATA,
    FS_PAR,
    FS_STOP
  } fstate_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic split3(input logic a, input logic b, input logic c);
    return !((a == b) && (b == c));
  endfunction

  // expected parity bit for the aligned word
  function automatic logic par_bit(input logic [DW-1:0] d, input logic nine, input logic odd);
    logic p;
    p = ^(nine ? d : {1'b0, d[DW-2:0]});
    return p ^ odd;
  endfunction

  // bit cells in one frame: start + data + parity + stop
  function automatic int unsigned frame_bits(input logic nine, input logic pen);
    return 32'd10 + {31'd0, nine} + {31'd0, pen};
  endfunction

endpackage

// File: rtl/uwr_baud_tick.sv
module uwr_baud_tick #(
  parameter int DIV_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim  = (div == '0) ? '0 : div - 1'b1;
  assign tick = (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= tick ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/uwr_frame_eng.sv
module uwr_frame_eng
  import uwr_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rx,
  input  logic          nine,
  input  logic          par_en,
  input  logic          par_odd,
  output logic          done,
  output logic [DW-1:0] word,
  output logic          ferr,
  output logic          perr,
  output logic          nerr
);
  localparam int SW = $clog2(OSR);
  localparam logic [SW-1:0] S_A   = SW'(OSR / 2 - 1);
  localparam logic [SW-1:0] S_B   = SW'(OSR / 2);
  localparam logic [SW-1:0] S_C   = SW'(OSR / 2 + 1);
  localparam logic [SW-1:0] S_END = SW'(OSR - 1);

  fstate_e       st;
  logic [SW-1:0] sub;
  logic [3:0]    bitn;
  logic [DW-1:0] shreg;
  logic          smp_a, smp_b, pbit, nacc, last_hi;
  logic          bit_v, bit_n;
  logic [3:0]    nbits;
  logic [DW-1:0] aligned;

  assign bit_v   = maj3(smp_a, smp_b, rx);
  assign bit_n   = split3(smp_a, smp_b, rx);
  assign nbits   = nine ? 4'd9 : 4'd8;
  assign aligned = nine ? shreg : {1'b0, shreg[DW-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= FS_IDLE; sub <= '0; bitn <= '0; shreg <= '0;
      smp_a <= 1'b1; smp_b <= 1'b1; pbit <= 1'b0; nacc <= 1'b0;
      last_hi <= 1'b0; done <= 1'b0; word <= '0;
      ferr <= 1'b0; perr <= 1'b0; nerr <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        if (st == FS_IDLE) begin
          if (!rx && last_hi) begin
            st <= FS_START; sub <= '0; nacc <= 1'b0;
          end else if (rx) begin
            last_hi <= 1'b1;
          end
        end else begin
          sub <= sub + 1'b1;
          if (sub == S_A) smp_a <= rx;
          if (sub == S_B) smp_b <= rx;
          if (sub == S_C) begin
            case (st)
              FS_START: begin
                if (bit_v) begin st <= FS_IDLE; last_hi <= 1'b1; end
                else nacc <= nacc | bit_n;
              end
              FS_DATA: begin
                shreg <= {bit_v, shreg[DW-1:1]};
                bitn  <= bitn + 1'b1;
                nacc  <= nacc | bit_n;
              end
              FS_PAR: begin
                pbit <= bit_v;
                nacc <= nacc | bit_n;
              end
              FS_STOP: begin
                st      <= FS_IDLE;
                last_hi <= bit_v;
                done    <= 1'b1;
                word    <= aligned;
                ferr    <= !bit_v;
                perr    <= par_en && (pbit != par_bit(aligned, nine, par_odd));
                nerr    <= nacc | bit_n;
              end
              default: ;
            endcase
          end
          if (sub == S_END) begin
            case (st)
              FS_START: begin st <= FS_DATA; bitn <= '0; end
              FS_DATA:  if (bitn == nbits) st <= par_en ? FS_PAR : FS_STOP;
              FS_PAR:   st <= FS_STOP;
              default: ;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/uwr_wake_ctl.sv
module uwr_wake_ctl
  import uwr_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx,
  input  logic nine,
  input  logic par_en,
  input  logic wake_addr,
  input  logic sleep_req,
  input  logic done,
  input  logic msb,
  output logic asleep,
  output logic wake_evt,
  output logic deliver
);
  localparam int IW = $clog2(OSR * (DW + 3) + 1);

  logic [IW-1:0] idle_cnt;
  logic [IW-1:0] thresh;
  logic          idle_full;

  assign thresh    = IW'(frame_bits(nine, par_en) * OSR);
  assign idle_full = (idle_cnt >= thresh);
  assign wake_evt  = asleep && !sleep_req &&
                     (wake_addr ? (done && msb) : idle_full);
  assign deliver   = done && !sleep_req && (!asleep || (wake_addr && msb));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      asleep   <= 1'b0;
    end else begin
      if (sleep_req || (tick && !rx))      idle_cnt <= '0;
      else if (tick && !idle_full)         idle_cnt <= idle_cnt + 1'b1;
      if (sleep_req)     asleep <= 1'b1;
      else if (wake_evt) asleep <= 1'b0;
    end
  end
endmodule

// File: rtl/uwr_rx_top.sv
module uwr_rx_top
  import uwr_pkg::*;
#(
  parameter int DIV_W = 13,
  parameter int OSR   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             nine_bit,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic             wake_addr,
  input  logic             sleep_req,
  output logic [DW-1:0]    rx_data,
  output logic             rx_valid,
  output logic             err_frame,
  output logic             err_parity,
  output logic             err_noise,
  output logic             err_any,
  output logic             asleep
);
  logic [1:0]    sync_q;
  logic          rx_s;
  logic          tick_w;
  logic          done_w, ferr_w, perr_w, nerr_w;
  logic [DW-1:0] word_w;
  logic          msb_w, wake_evt_w, deliver_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rx_i};
  end
  assign rx_s  = sync_q[1];
  assign msb_w = nine_bit ? word_w[DW-1] : word_w[DW-2];

  uwr_baud_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick_w)
  );

  uwr_frame_eng #(.OSR(OSR)) u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .rx(rx_s),
    .nine(nine_bit), .par_en(par_en), .par_odd(par_odd),
    .done(done_w), .word(word_w), .ferr(ferr_w), .perr(perr_w), .nerr(nerr_w)
  );

  uwr_wake_ctl #(.OSR(OSR)) u_wake (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .rx(rx_s),
    .nine(nine_bit), .par_en(par_en), .wake_addr(wake_addr),
    .sleep_req(sleep_req), .done(done_w), .msb(msb_w),
    .asleep(asleep), .wake_evt(wake_evt_w), .deliver(deliver_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0; rx_valid <= 1'b0;
      err_frame <= 1'b0; err_parity <= 1'b0; err_noise <= 1'b0; err_any <= 1'b0;
    end else begin
      rx_valid <= deliver_w;
      if (deliver_w) begin
        rx_data    <= word_w;
        err_frame  <= ferr_w;
        err_parity <= perr_w;
        err_noise  <= nerr_w;
        err_any    <= ferr_w | perr_w | nerr_w;
      end
    end
  end
endmodule

// File: rtl/uwr_rx_chk.sv
module uwr_rx_chk #(
  parameter int DIV_W = 13,
  parameter int DW    = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [DIV_W-1:0] baud_div,
  input logic             sleep_req,
  input logic             asleep,
  input logic             wake_evt,
  input logic             rx_valid,
  input logic [DW-1:0]    rx_data
);
  // R1
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && baud_div > 1 && $stable(baud_div)) |=> !tick);

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_data));

  // R9
  sleep_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |=> asleep);

  // R9
  asleep_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !asleep);

  // R10
  wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |-> $past(wake_evt));
endmodule

bind uwr_rx_top uwr_rx_chk #(.DIV_W(DIV_W), .DW(uwr_pkg::DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_w), .baud_div(baud_div),
  .sleep_req(sleep_req), .asleep(asleep), .wake_evt(wake_evt_w),
  .rx_valid(rx_valid), .rx_data(rx_data)
);

// File: tb/sim_uwr_rx_top.sv
`timescale 1ns/1ps
module sim_uwr_rx_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx = 1'b1;
  logic [12:0] div_b = 13'd4;
  logic        nine = 1'b0, pen = 1'b0, podd = 1'b0, waddr = 1'b0, slp = 1'b0;
  logic [8:0]  rx_data;
  logic        rx_valid, ef, ep, en, ea, asleep;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [8:0] last_data = '0;

  typedef struct {
    logic [8:0] d;
    logic fe, pe, ne;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  uwr_rx_top u0 (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .baud_div(div_b),
    .nine_bit(nine), .par_en(pen), .par_odd(podd), .wake_addr(waddr),
    .sleep_req(slp), .rx_data(rx_data), .rx_valid(rx_valid),
    .err_frame(ef), .err_parity(ep), .err_noise(en), .err_any(ea),
    .asleep(asleep)
  );

  task automatic check(input bit ok, input string msg, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, expv);
    end
  endtask

  // one bit cell; optional glitch hits only the middle mid-cell sample (R5)
  task automatic drive_bit(input logic v, input bit g);
    int bt;
    bt = 16 * int'(div_b);
    for (int c = 0; c < bt; c++) begin
      @(negedge clk);
      rx = (g && c >= 36 && c < 40) ? !v : v;
    end
  endtask

  task automatic send_frame(input logic [8:0] d, input bit bad_stop, input bit bad_par,
                            input int glitch, input bit expect_it, input string tag);
    logic [8:0] dm;
    logic p;
    int nb;
    exp_t e;
    nb = nine ? 9 : 8;
    dm = nine ? d : {1'b0, d[7:0]};
    p  = (($countones(dm) % 2) == 1) ^ podd ^ bad_par;
    if (expect_it) begin
      e.d = dm; e.fe = bad_stop; e.pe = bad_par; e.ne = (glitch >= 0); e.tag = tag;
      sb.push_back(e);
    end
    drive_bit(1'b0, 0);
    for (int i = 0; i < nb; i++) drive_bit(dm[i], glitch == i);
    if (pen) drive_bit(p, 0);
    drive_bit(!bad_stop, 0);
    drive_bit(1'b1, 0);
    if (bad_stop) drive_bit(1'b1, 0);
  endtask

  task automatic pulse_sleep();
    @(negedge clk); slp = 1'b1;
    @(negedge clk); slp = 1'b0;
  endtask

  // monitor: pops the scoreboard on each strobe (R2..R7)
  initial begin
    forever begin
      @(negedge clk);
      if (rx_valid) begin
        if (sb.size() == 0) begin
          check(0, "R9 strobe with nothing expected", rx_data, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(rx_data == e.d, {e.tag, " data"}, rx_data, e.d);
          check({ef, ep, en} == {e.fe, e.pe, e.ne}, {e.tag, " flags R4 R3 R5"},
                {ef, ep, en}, {e.fe, e.pe, e.ne});
          // R6 summary bit
          check(ea == (e.fe | e.pe | e.ne), {e.tag, " R6 err_any"}, ea, e.fe | e.pe | e.ne);
          last_data = rx_data;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R12 reset state
    check({rx_valid, rx_data, ef, ep, en, ea, asleep} == '0, "R12 reset outputs",
          {rx_valid, rx_data, ef, ep, en, ea, asleep}, 0);
    rst_n = 1'b1;
    repeat (200) @(negedge clk);

    // R1 R2 basic 8-bit frames
    send_frame(9'h0A5, 0, 0, -1, 1, "R2 8bit A5");
    send_frame(9'h03C, 0, 0, -1, 1, "R2 8bit 3C");
    send_frame(9'h1FF, 0, 0, -1, 1, "R2 8bit top masked");
    nine = 1'b1;
    send_frame(9'h1A5, 0, 0, -1, 1, "R2 9bit 1A5");
    nine = 1'b0;

    // R3 parity
    pen = 1'b1; podd = 1'b0;
    send_frame(9'h05A, 0, 0, -1, 1, "R3 even ok");
    send_frame(9'h05A, 0, 1, -1, 1, "R3 even bad");
    podd = 1'b1;
    send_frame(9'h05B, 0, 0, -1, 1, "R3 odd ok");
    send_frame(9'h011, 0, 1, -1, 1, "R3 odd bad");
    pen = 1'b0; podd = 1'b0;

    // R4 framing
    send_frame(9'h077, 1, 0, -1, 1, "R4 stop low");
    // R5 noise, majority keeps data
    send_frame(9'h0F0, 0, 0, 3, 1, "R5 glitch bit3");

    // R8 false start
    repeat (16) @(negedge clk) rx = 1'b0;
    rx = 1'b1;
    repeat (128) @(negedge clk);
    send_frame(9'h042, 0, 0, -1, 1, "R8 after false start");

    // R1 other divisor
    div_b = 13'd7;
    repeat (200) @(negedge clk);
    send_frame(9'h081, 0, 0, -1, 1, "R1 div7");
    div_b = 13'd4;
    repeat (200) @(negedge clk);

    // R9 R10 idle-line wake
    waddr = 1'b0;
    pulse_sleep();
    check(asleep == 1'b1, "R9 asleep after request", asleep, 1);
    send_frame(9'h055, 0, 0, -1, 0, "R9 dropped");
    check(asleep == 1'b1, "R10 still asleep after short gap", asleep, 1);
    check(rx_data == last_data, "R9 data unchanged by dropped frame", rx_data, last_data);
    repeat (64 * 12) @(negedge clk);
    check(asleep == 1'b0, "R10 awake after idle frame time", asleep, 0);
    send_frame(9'h066, 0, 0, -1, 1, "R10 after wake");

    // R11 marked-frame wake
    waddr = 1'b1;
    pulse_sleep();
    send_frame(9'h012, 0, 0, -1, 0, "R11 dropped");
    repeat (64 * 14) @(negedge clk);
    check(asleep == 1'b1, "R11 idle does not wake", asleep, 1);
    send_frame(9'h092, 0, 0, -1, 1, "R11 marked 8bit");
    check(asleep == 1'b0, "R11 awake after marked frame", asleep, 0);
    nine = 1'b1;
    pulse_sleep();
    send_frame(9'h0FF, 0, 0, -1, 0, "R11 9bit dropped");
    check(asleep == 1'b1, "R11 9bit still asleep", asleep, 1);
    send_frame(9'h101, 0, 0, -1, 1, "R11 marked 9bit");
    check(asleep == 1'b0, "R11 9bit awake", asleep, 0);

    repeat (200) @(negedge clk);
    // R7 every expected word arrived exactly once
    check(sb.size() == 0, "R7 scoreboard drained", sb.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule